// File: doc/BRIEF.md
# Kernel Cache-Maintenance Request Tracker

This block keeps count of the cache invalidate requests and the cache writeback requests that are still in flight for one running kernel. A dispatcher tells it when invalidation begins, reports how many requests it has just issued and how many have just come back, and may declare the invalidation finished outright. From those events the block reports whether invalidation has begun, whether it has finished, how many writebacks are pending and whether a flush has drained.

The invalidate count has three kinds of value. A reserved "not begun" code reads as all ones (-1 in two's complement). Zero means finished, and a positive value is the number of requests still pending. The writeback count has no reserved code and rests at zero. In each channel, the issued and returned amounts arriving in one cycle are netted before they are applied. An update that would push a count below zero or above its largest value is dropped, and a sticky protocol-error flag is raised.

Top module: `kcm_tracker`

## Requirements
- R1: After reset, `inv_count` reads all ones (-1). `inv_started`, `inv_done`, `flush_done` and `proto_err` read 0, and `wb_count` reads 0.
- R2: `inv_start` while the invalidate count is -1 moves it to 0 at the next edge, so `inv_started` rises. Invalidate updates in that same cycle are applied to the new 0. `inv_start` has no effect once invalidation has begun, and `inv_started` then stays 1 until reset.
- R3: When invalidation has begun, the next invalidate count is the current count plus `inv_issue_cnt` (when `inv_issue_vld`) minus `inv_retire_cnt` (when `inv_retire_vld`). Both amounts in one cycle are netted into a single update.
- R4: An invalidate update whose result would be below 0 or above 2^(CNT_W-1)-1 is discarded: the count keeps its current value, and `proto_err` is set.
- R5: An invalidate update while the count is -1 and `inv_start` is low is discarded: the count stays -1, and `proto_err` is set.
- R6: `inv_force_done` sets the invalidate count to 0 at the next edge, from any state including -1. Invalidate updates in the same cycle are ignored and raise no error.
- R7: `inv_done` is 1 exactly when invalidation has begun and the invalidate count is 0. The -1 state never reads as done.
- R8: The writeback count starts at 0 and follows the same netted update rule as R3. An update that would take it below 0 or above 2^(CNT_W-1)-1 is discarded and sets `proto_err`.
- R9: `flush_done` rises when an accepted writeback update takes the count from a positive value to 0. It holds while the count stays 0, and it clears when an accepted update makes the count positive.
- R10: `proto_err` stays 1 from the cycle after the first discarded update until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inv_start | input | 1 | Begin invalidation (-1 to 0) |
| inv_force_done | input | 1 | Force the invalidate count to 0 |
| inv_issue_vld | input | 1 | `inv_issue_cnt` is valid |
| inv_issue_cnt | input | STEP_W | Invalidates issued this cycle |
| inv_retire_vld | input | 1 | `inv_retire_cnt` is valid |
| inv_retire_cnt | input | STEP_W | Invalidates completed this cycle |
| wb_issue_vld | input | 1 | `wb_issue_cnt` is valid |
| wb_issue_cnt | input | STEP_W | Writebacks issued this cycle |
| wb_retire_vld | input | 1 | `wb_retire_cnt` is valid |
| wb_retire_cnt | input | STEP_W | Writebacks completed this cycle |
| inv_started | output | 1 | Invalidation has begun |
| inv_done | output | 1 | Invalidation finished |
| inv_count | output | CNT_W | Invalidate count, two's complement, -1 = not begun |
| wb_count | output | CNT_W | Pending writebacks |
| flush_done | output | 1 | Writebacks drained after being pending |
| proto_err | output | 1 | Sticky: an update was discarded |

## Verification
Several behaviours are checked on every cycle by the assertions:
- `inv_done` never appears without `inv_started`.
- Once begun, invalidation never returns to the not-begun state.
- A force takes the count to zero, and neither count goes negative.
- `flush_done` is only seen with an empty writeback count.
- The error flag is sticky.

The exact arithmetic can only be shown by the bench's scenarios. This covers netting same-cycle issue and retire amounts, the start-plus-issue transient, and the discard of an overflowing or underflowing update with the count left unchanged. The same holds for the order of flush-done set and clear, and for updates refused before start.

// File: rtl/kcm_pkg.sv
`timescale 1ns/1ps
package kcm_pkg;

    // Outcome of one channel's update in a cycle.
    typedef enum logic [1:0] {
        VERD_IDLE   = 2'd0,
        VERD_APPLY  = 2'd1,
        VERD_REJECT = 2'd2
    } verdict_e;

    // Decide what happens to a pending update.
    // has_upd : an issue or retire amount is present
    // in_range: the candidate result lies inside the counter range
    // open    : the channel accepts updates (invalidation begun)
    function automatic verdict_e classify(input logic has_upd,
                                          input logic in_range,
                                          input logic open);
        if (!has_upd)
            return VERD_IDLE;
        else if (open && in_range)
            return VERD_APPLY;
        else
            return VERD_REJECT;
    endfunction

endpackage

// File: rtl/kcm_net_delta.sv
`timescale 1ns/1ps
// Nets the issued and retired amounts of one cycle into one signed step.
module kcm_net_delta #(
    parameter int STEP_W = 4
) (
    input  logic                     issue_vld,
    input  logic [STEP_W-1:0]        issue_cnt,
    input  logic                     retire_vld,
    input  logic [STEP_W-1:0]        retire_cnt,
    output logic signed [STEP_W:0]   delta,
    output logic                     has_upd
);
    logic [STEP_W:0] up_ext;
    logic [STEP_W:0] dn_ext;

    always_comb begin
        up_ext  = issue_vld  ? {1'b0, issue_cnt}  : '0;
        dn_ext  = retire_vld ? {1'b0, retire_cnt} : '0;
        delta   = $signed(up_ext - dn_ext);
        has_upd = issue_vld | retire_vld;
    end
endmodule

// File: rtl/kcm_range_check.sv
`timescale 1ns/1ps
// Adds a signed step to a count and reports whether the result stays in
// the range 0 .. 2^(CNT_W-1)-1.
module kcm_range_check #(
    parameter int CNT_W = 8,
    parameter int DW    = 5
) (
    input  logic signed [CNT_W-1:0] base,
    input  logic signed [DW-1:0]    delta,
    output logic        [CNT_W-1:0] sum,
    output logic                    in_range
);
    localparam int WW = CNT_W + 2;
    localparam logic signed [WW-1:0] TOP = WW'((2 ** (CNT_W - 1)) - 1);

    logic signed [WW-1:0] base_w;
    logic signed [WW-1:0] delta_w;
    logic signed [WW-1:0] wide;

    always_comb begin
        base_w   = {{2{base[CNT_W-1]}}, base};
        delta_w  = {{(WW - DW){delta[DW-1]}}, delta};
        wide     = base_w + delta_w;
        in_range = (wide >= 0) && (wide <= TOP);
        sum      = wide[CNT_W-1:0];
    end
endmodule

// File: rtl/kcm_tracker.sv
`timescale 1ns/1ps
module kcm_tracker #(
    parameter int CNT_W  = 8,
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_start,
    input  logic              inv_force_done,
    input  logic              inv_issue_vld,
    input  logic [STEP_W-1:0] inv_issue_cnt,
    input  logic              inv_retire_vld,
    input  logic [STEP_W-1:0] inv_retire_cnt,
    input  logic              wb_issue_vld,
    input  logic [STEP_W-1:0] wb_issue_cnt,
    input  logic              wb_retire_vld,
    input  logic [STEP_W-1:0] wb_retire_cnt,
    output logic              inv_started,
    output logic              inv_done,
    output logic [CNT_W-1:0]  inv_count,
    output logic [CNT_W-1:0]  wb_count,
    output logic              flush_done,
    output logic              proto_err
);
    import kcm_pkg::*;

    localparam int DW     = STEP_W + 1;
    localparam int NCH    = 2;
    localparam int CH_INV = 0;
    localparam int CH_WB  = 1;
    localparam logic [CNT_W-1:0] NOT_BEGUN = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] inv_cnt;
        logic [CNT_W-1:0] wb_cnt;
        logic             wb_drained;
        logic             err;
    } state_t;

    state_t s_d, s_q;

    logic [NCH-1:0]              iss_vld, ret_vld, has_upd, in_range;
    logic [NCH-1:0][STEP_W-1:0]  iss_cnt, ret_cnt;
    logic signed [DW-1:0]        delta [NCH];
    logic signed [CNT_W-1:0]     base  [NCH];
    logic [CNT_W-1:0]            sum   [NCH];
    logic [CNT_W-1:0]            inv_base_u;
    verdict_e                    inv_verd, wb_verd;

    assign iss_vld = {wb_issue_vld, inv_issue_vld};
    assign ret_vld = {wb_retire_vld, inv_retire_vld};
    assign iss_cnt = {wb_issue_cnt, inv_issue_cnt};
    assign ret_cnt = {wb_retire_cnt, inv_retire_cnt};

    // A start seen in the not-begun state rebases the invalidate count to 0
    // before this cycle's update is added.
    assign inv_base_u  = (inv_start && (s_q.inv_cnt == NOT_BEGUN)) ? '0 : s_q.inv_cnt;
    assign base[CH_INV] = $signed(inv_base_u);
    assign base[CH_WB]  = $signed(s_q.wb_cnt);

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        kcm_net_delta #(
            .STEP_W (STEP_W)
        ) u_net (
            .issue_vld  (iss_vld[g]),
            .issue_cnt  (iss_cnt[g]),
            .retire_vld (ret_vld[g]),
            .retire_cnt (ret_cnt[g]),
            .delta      (delta[g]),
            .has_upd    (has_upd[g])
        );

        kcm_range_check #(
            .CNT_W (CNT_W),
            .DW    (DW)
        ) u_rng (
            .base     (base[g]),
            .delta    (delta[g]),
            .sum      (sum[g]),
            .in_range (in_range[g])
        );
    end

    always_comb begin
        s_d      = s_q;
        inv_verd = classify(has_upd[CH_INV], in_range[CH_INV],
                            inv_base_u != NOT_BEGUN);
        wb_verd  = classify(has_upd[CH_WB], in_range[CH_WB], 1'b1);

        // Invalidate channel: force wins over start and updates.
        if (inv_force_done) begin
            s_d.inv_cnt = '0;
        end else begin
            unique case (inv_verd)
                VERD_APPLY:  s_d.inv_cnt = sum[CH_INV];
                VERD_REJECT: begin
                    s_d.inv_cnt = inv_base_u;
                    s_d.err     = 1'b1;
                end
                default:     s_d.inv_cnt = inv_base_u;
            endcase
        end

        // Writeback channel.
        unique case (wb_verd)
            VERD_APPLY: begin
                s_d.wb_cnt = sum[CH_WB];
                if (sum[CH_WB] != '0)
                    s_d.wb_drained = 1'b0;
                else if (s_q.wb_cnt != '0)
                    s_d.wb_drained = 1'b1;
            end
            VERD_REJECT: s_d.err = 1'b1;
            default:     s_d.wb_cnt = s_q.wb_cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.inv_cnt    <= NOT_BEGUN;
            s_q.wb_cnt     <= '0;
            s_q.wb_drained <= 1'b0;
            s_q.err        <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign inv_started = (s_q.inv_cnt != NOT_BEGUN);
    assign inv_done    = inv_started && (s_q.inv_cnt == '0);
    assign inv_count   = s_q.inv_cnt;
    assign wb_count    = s_q.wb_cnt;
    assign flush_done  = s_q.wb_drained;
    assign proto_err   = s_q.err;
endmodule

// File: rtl/kcm_tracker_chk.sv
`timescale 1ns/1ps
module kcm_tracker_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             inv_start,
    input logic             inv_force_done,
    input logic             inv_started,
    input logic             inv_done,
    input logic [CNT_W-1:0] inv_count,
    input logic [CNT_W-1:0] wb_count,
    input logic             flush_done,
    input logic             proto_err
);
    // R7: done is never reported in the not-begun state
    p_done_needs_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inv_done |-> inv_started);

    // R2: once begun, invalidation stays begun until reset
    p_started_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inv_started |=> inv_started);

    // R2: a start from the not-begun state opens the channel
    p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!inv_started && inv_start) |=> inv_started);

    // R5: without start or force, the not-begun state is kept
    p_closed_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!inv_started && !inv_start && !inv_force_done) |=> !inv_started);

    // R6: force always yields zero at the next edge
    p_force_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inv_force_done |=> (inv_count == '0));

    // R4: a begun invalidate count is never negative
    p_inv_nonneg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inv_started |-> !inv_count[CNT_W-1]);

    // R8: writeback count is never negative
    p_wb_nonneg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_count[CNT_W-1]);

    // R9: drained only with an empty writeback count
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> (wb_count == '0));

    // R10: error flag is sticky
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
endmodule

bind kcm_tracker kcm_tracker_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .inv_start      (inv_start),
    .inv_force_done (inv_force_done),
    .inv_started    (inv_started),
    .inv_done       (inv_done),
    .inv_count      (inv_count),
    .wb_count       (wb_count),
    .flush_done     (flush_done),
    .proto_err      (proto_err)
);

// File: tb/sim_kcm_tracker.sv
`timescale 1ns/1ps
module sim_kcm_tracker;
    localparam int CNT_W  = 8;
    localparam int STEP_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic inv_start, inv_force_done;
    logic inv_issue_vld, inv_retire_vld, wb_issue_vld, wb_retire_vld;
    logic [STEP_W-1:0] inv_issue_cnt, inv_retire_cnt, wb_issue_cnt, wb_retire_cnt;
    logic inv_started, inv_done, flush_done, proto_err;
    logic [CNT_W-1:0] inv_count, wb_count;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    kcm_tracker #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .inv_start(inv_start), .inv_force_done(inv_force_done),
        .inv_issue_vld(inv_issue_vld), .inv_issue_cnt(inv_issue_cnt),
        .inv_retire_vld(inv_retire_vld), .inv_retire_cnt(inv_retire_cnt),
        .wb_issue_vld(wb_issue_vld), .wb_issue_cnt(wb_issue_cnt),
        .wb_retire_vld(wb_retire_vld), .wb_retire_cnt(wb_retire_cnt),
        .inv_started(inv_started), .inv_done(inv_done),
        .inv_count(inv_count), .wb_count(wb_count),
        .flush_done(flush_done), .proto_err(proto_err)
    );

    typedef struct packed {
        logic       st;  logic       fd;
        logic       iv;  logic [3:0] ic;
        logic       rv;  logic [3:0] rc;
        logic       wv;  logic [3:0] wc;
        logic       xv;  logic [3:0] xc;
        logic [7:0] e_inv; logic [7:0] e_wb;
        logic e_st; logic e_dn; logic e_fl; logic e_er;
    } vec_t;

    localparam int NV = 15;
    // Expected values are those seen one cycle after the row is applied.
    localparam vec_t TBL [NV] = '{
        // start from -1 -> 0, done (R2, R7)
        '{1'b1,1'b0, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 8'd0, 8'd0, 1'b1,1'b1,1'b0,1'b0},
        // issue 5 (R3)
        '{1'b0,1'b0, 1'b1,4'd5, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 8'd5, 8'd0, 1'b1,1'b0,1'b0,1'b0},
        // issue 3 retire 2 netted (R3)
        '{1'b0,1'b0, 1'b1,4'd3, 1'b1,4'd2, 1'b0,4'd0, 1'b0,4'd0, 8'd6, 8'd0, 1'b1,1'b0,1'b0,1'b0},
        // retire 6 -> done (R7)
        '{1'b0,1'b0, 1'b0,4'd0, 1'b1,4'd6, 1'b0,4'd0, 1'b0,4'd0, 8'd0, 8'd0, 1'b1,1'b1,1'b0,1'b0},
        // second start ignored, issue 2 (R2)
        '{1'b1,1'b0, 1'b1,4'd2, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 8'd2, 8'd0, 1'b1,1'b0,1'b0,1'b0},
        // wb issue 4 (R8)
        '{1'b0,1'b0, 1'b0,4'd0, 1'b0,4'd0, 1'b1,4'd4, 1'b0,4'd0, 8'd2, 8'd4, 1'b1,1'b0,1'b0,1'b0},
        // wb issue 1 retire 3 (R8)
        '{1'b0,1'b0, 1'b0,4'd0, 1'b0,4'd0, 1'b1,4'd1, 1'b1,4'd3, 8'd2, 8'd2, 1'b1,1'b0,1'b0,1'b0},
        // wb retire 2 -> drained (R9)
        '{1'b0,1'b0, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b1,4'd2, 8'd2, 8'd0, 1'b1,1'b0,1'b1,1'b0},
        // idle: drained holds (R9)
        '{1'b0,1'b0, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 8'd2, 8'd0, 1'b1,1'b0,1'b1,1'b0},
        // wb issue 1 clears drained (R9)
        '{1'b0,1'b0, 1'b0,4'd0, 1'b0,4'd0, 1'b1,4'd1, 1'b0,4'd0, 8'd2, 8'd1, 1'b1,1'b0,1'b0,1'b0},
        // both channels retire to 0 (R3, R8, R9)
        '{1'b0,1'b0, 1'b0,4'd0, 1'b1,4'd2, 1'b0,4'd0, 1'b1,4'd1, 8'd0, 8'd0, 1'b1,1'b1,1'b1,1'b0},
        // inv issue 4
        '{1'b0,1'b0, 1'b1,4'd4, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 8'd4, 8'd0, 1'b1,1'b0,1'b1,1'b0},
        // force with issue 3: force wins, no error (R6)
        '{1'b0,1'b1, 1'b1,4'd3, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 8'd0, 8'd0, 1'b1,1'b1,1'b1,1'b0},
        // retire below zero discarded (R4)
        '{1'b0,1'b0, 1'b0,4'd0, 1'b1,4'd1, 1'b0,4'd0, 1'b0,4'd0, 8'd0, 8'd0, 1'b1,1'b1,1'b1,1'b1},
        // idle: error sticky (R10)
        '{1'b0,1'b0, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 1'b0,4'd0, 8'd0, 8'd0, 1'b1,1'b1,1'b1,1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        inv_start      = v.st;
        inv_force_done = v.fd;
        inv_issue_vld  = v.iv; inv_issue_cnt  = v.ic;
        inv_retire_vld = v.rv; inv_retire_cnt = v.rc;
        wb_issue_vld   = v.wv; wb_issue_cnt   = v.wc;
        wb_retire_vld  = v.xv; wb_retire_cnt  = v.xc;
    endtask

    task automatic idle();
        drive('0);
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Apply one cycle of stimulus at a negedge, then step to the next negedge.
    task automatic step(input vec_t v);
        drive(v);
        @(negedge clk);
        idle();
    endtask

    function automatic vec_t mk(input logic st, input logic fd,
                                input logic iv, input logic [3:0] ic,
                                input logic rv, input logic [3:0] rc,
                                input logic wv, input logic [3:0] wc,
                                input logic xv, input logic [3:0] xc);
        vec_t v;
        v = '0;
        v.st = st; v.fd = fd; v.iv = iv; v.ic = ic; v.rv = rv; v.rc = rc;
        v.wv = wv; v.wc = wc; v.xv = xv; v.xc = xc;
        return v;
    endfunction

    initial begin
        #(20 * 20000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1: reset state
        chk("R1 inv_count",   32'(inv_count),   32'hFF);
        chk("R1 inv_started", 32'(inv_started), 0);
        chk("R1 inv_done",    32'(inv_done),    0);
        chk("R1 wb_count",    32'(wb_count),    0);
        chk("R1 flush_done",  32'(flush_done),  0);
        chk("R1 proto_err",   32'(proto_err),   0);

        for (int i = 0; i < NV; i++) begin
            step(TBL[i]);
            chk($sformatf("R3 inv_count row %0d", i),  32'(inv_count),   32'(TBL[i].e_inv));
            chk($sformatf("R8 wb_count row %0d", i),   32'(wb_count),    32'(TBL[i].e_wb));
            chk($sformatf("R2 started row %0d", i),    32'(inv_started), 32'(TBL[i].e_st));
            chk($sformatf("R7 done row %0d", i),       32'(inv_done),    32'(TBL[i].e_dn));
            chk($sformatf("R9 flush row %0d", i),      32'(flush_done),  32'(TBL[i].e_fl));
            chk($sformatf("R10 err row %0d", i),       32'(proto_err),   32'(TBL[i].e_er));
        end

        // R5: update before start is discarded and flagged
        do_reset();
        step(mk(0,0, 1,4'd3, 0,4'd0, 0,4'd0, 0,4'd0));
        chk("R5 inv_count stays -1", 32'(inv_count),   32'hFF);
        chk("R5 not started",        32'(inv_started), 0);
        chk("R5 done low at -1",     32'(inv_done),    0);
        chk("R5 error raised",       32'(proto_err),   1);

        // R8: writeback underflow discarded
        do_reset();
        step(mk(0,0, 0,4'd0, 0,4'd0, 0,4'd0, 1,4'd1));
        chk("R8 wb stays 0",       32'(wb_count),   0);
        chk("R8 error raised",     32'(proto_err),  1);
        chk("R9 no drain from 0",  32'(flush_done), 0);

        // R2: start with issue in the same cycle skips the done transient
        do_reset();
        step(mk(1,0, 1,4'd3, 0,4'd0, 0,4'd0, 0,4'd0));
        chk("R2 start+issue count", 32'(inv_count),   3);
        chk("R2 start+issue began", 32'(inv_started), 1);
        chk("R7 start+issue done",  32'(inv_done),    0);

        // R6: force from the not-begun state
        do_reset();
        step(mk(0,1, 0,4'd0, 0,4'd0, 0,4'd0, 0,4'd0));
        chk("R6 force from -1 count", 32'(inv_count),   0);
        chk("R6 force from -1 began", 32'(inv_started), 1);
        chk("R6 force done",          32'(inv_done),    1);

        // R4: overflow above 127 discarded
        do_reset();
        step(mk(1,0, 0,4'd0, 0,4'd0, 0,4'd0, 0,4'd0));
        for (int k = 0; k < 8; k++)
            step(mk(0,0, 1,4'd15, 0,4'd0, 0,4'd0, 0,4'd0));
        chk("R4 filled to 120",  32'(inv_count), 120);
        chk("R4 no error yet",   32'(proto_err), 0);
        step(mk(0,0, 1,4'd15, 0,4'd0, 0,4'd0, 0,4'd0));
        chk("R4 overflow kept",  32'(inv_count), 120);
        chk("R4 overflow error", 32'(proto_err), 1);
        step(mk(0,0, 0,4'd0, 1,4'd10, 0,4'd0, 0,4'd0));
        chk("R3 retire after err", 32'(inv_count), 110);
        chk("R10 error held",      32'(proto_err), 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule